// File: doc/BRIEF.md
# Message Signalled Interrupt Capability Registers

This block holds one message-signalled interrupt capability in a device's configuration space. Two build options choose whether the message address is 32 or 64 bits wide and whether vectors can be masked one by one. The options move the message data, mask and pending fields, change which bits can be written, and set how many bytes the capability covers. Configuration accesses are dword-aligned, with byte enables. The block decides whether an access falls inside the capability, returns read data, and merges write data into the fields that can be written.

The block reports three single-cycle events to the rest of the device: interrupts were just switched on, interrupts were just switched off, or the message address or data changed while interrupts were on. Local interrupt requests come in with a vector number. Each accepted request becomes one message write, with the stored address and a data word that carries the vector in its low bits. The message is presented on a valid/acknowledge port and held there until it is acknowledged. A masked vector is recorded as pending and is sent once its mask bit is cleared.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset every writable field is zero, messages are off and `msgValid` is low. Dword 0 reads as control[15:0] in bits 31:16, the next pointer in bits 15:8 and the capability ID in bits 7:0.
- R2: An access hits only when `cfgOffset[1:0]` is 0, at least one byte enable is set, and the highest enabled byte (offset plus enable index) is below the capability length. The length is 10 bytes for 32-bit without masking, 20 for 32-bit with masking, 14 for 64-bit without masking and 24 for 64-bit with masking. A write that misses changes nothing and raises no event.
- R3: In the control word, only bit 0 (enable), bits 6:4 (multiple-message enable) and bit 10 (extended-data enable) take writes. Bits 3:1 return the capable-vector log2 parameter, bit 7 returns the 64-bit option and bit 8 returns the masking option. All other control bits read as zero.
- R4: The low address dword sits at offset 4, and its bits 1:0 always read as zero. Each write changes only the bytes whose enable is set.
- R5: With 64-bit addressing, the high address dword sits at offset 8. Writing either half of the address leaves the other half unchanged.
- R6: The message data dword sits at offset 12 with 64-bit addressing and at offset 8 without it. Message data is in bits 15:0 and extended data in bits 31:16. With masking, the mask dword follows the data dword and can be fully written. The pending dword follows the mask dword and ignores writes.
- R7: A control write that changes enable from 0 to 1 raises `enabledPulse` for one cycle. One that changes it from 1 to 0 raises `disabledPulse` for one cycle. Any other write raises neither.
- R8: `routeUpdate` pulses for one cycle after a write that leaves enable at 1 and changes the 64-bit address or the 16-bit message data. A write that changes neither does not raise it.
- R9: A request whose vector is unmasked, made while enabled, produces `msgValid` with `msgAddr` set to the full address. `msgData` is the stored data with its low `mme` bits replaced by the low bits of the vector. Address and data hold steady until `msgAck`.
- R10: A request made while enable is 0 is ignored: no message is sent and no pending bit is set.
- R11: A request for a masked vector sets that vector's pending bit and sends nothing. Clearing the mask bit later sends the message and clears the pending bit.
- R12: When several vectors are pending and unmasked, they are sent one message at a time, lowest vector number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Configuration access present this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgOffset | input | 8 | Byte offset from the capability base |
| cfgByteEn | input | 4 | Byte enables of the dword |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data (combinational, zero on a miss) |
| cfgHit | output | 1 | Access lies inside the capability |
| irqReq | input | 1 | Local interrupt request strobe |
| irqVec | input | 5 | Vector number of the request |
| msgValid | output | 1 | Message write is presented |
| msgAck | input | 1 | Message write accepted |
| msgAddr | output | 64 | Message address |
| msgData | output | 16 | Message data |
| enabledPulse | output | 1 | Interrupts just switched on |
| disabledPulse | output | 1 | Interrupts just switched off |
| routeUpdate | output | 1 | Address or data changed while enabled |

## Verification
The hit test is swept over every offset and every byte-enable pattern on two builds: 64-bit with masking, and 32-bit without. This separates the four capability lengths from the alignment rule. Writes of all ones, of a single byte and of the value already stored show apart the writable masks, the byte merging and the detection of a change for the route event. Requests arrive in four situations: with enable off, with the vector masked, with the vector unmasked, and with several vectors pending at once. These show the drop path, the pending path and the lowest-vector-first order, and the vector is checked in the low bits of the message data.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int MSI_VECS  = 32;
  localparam int MSI_VEC_W = $clog2(MSI_VECS);

  // strobes from control to datapath
  typedef struct packed {
    logic selHdr;
    logic selAddrLo;
    logic selAddrHi;
    logic selData;
    logic selMask;
    logic selPend;
    logic doWrite;
    logic launch;
    logic [MSI_VEC_W-1:0] launchVec;
  } strobe_t;

  // datapath state reported back to control
  typedef struct packed {
    logic en;
    logic [MSI_VECS-1:0] ready;
  } status_t;

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [3:0] be);
    logic [31:0] res;
    for (int i = 0; i < 4; i++)
      res[i*8 +: 8] = be[i] ? newVal[i*8 +: 8] : oldVal[i*8 +: 8];
    return res;
  endfunction
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit ADDR64   = 1'b1,
  parameter bit MASKABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgValid,
  input  logic       cfgWrite,
  input  logic [7:0] cfgOffset,
  input  logic [3:0] cfgByteEn,
  input  status_t    stat,
  input  logic       msgAck,
  output strobe_t    strb,
  output logic       cfgHit,
  output logic       msgValid
);
  localparam int DATA_OFF = ADDR64 ? 12 : 8;
  localparam int MASK_OFF = DATA_OFF + 4;
  localparam int PEND_OFF = MASK_OFF + 4;
  localparam int CAP_LEN  = MASKABLE ? PEND_OFF + 4 : DATA_OFF + 2;

  logic [1:0] topByte;
  logic [8:0] endByte;
  logic [MSI_VEC_W-1:0] pickVec;
  logic anyReady;
  logic launch;

  // highest enabled byte decides whether the access stays inside the span
  always_comb begin
    topByte = 2'd0;
    for (int i = 0; i < 4; i++)
      if (cfgByteEn[i]) topByte = 2'(i);
    endByte = {1'b0, cfgOffset} + {7'd0, topByte};
    cfgHit  = cfgValid && (cfgByteEn != 4'd0) && (cfgOffset[1:0] == 2'b00)
              && (endByte < 9'(CAP_LEN));
  end

  // lowest ready vector wins
  always_comb begin
    pickVec = '0;
    for (int i = MSI_VECS - 1; i >= 0; i--)
      if (stat.ready[i]) pickVec = MSI_VEC_W'(i);
  end

  assign anyReady = |stat.ready;
  assign launch   = !msgValid && stat.en && anyReady;

  always_comb begin
    strb.selHdr    = cfgHit && (cfgOffset == 8'd0);
    strb.selAddrLo = cfgHit && (cfgOffset == 8'd4);
    strb.selAddrHi = cfgHit && ADDR64 && (cfgOffset == 8'd8);
    strb.selData   = cfgHit && (cfgOffset == 8'(DATA_OFF));
    strb.selMask   = cfgHit && MASKABLE && (cfgOffset == 8'(MASK_OFF));
    strb.selPend   = cfgHit && MASKABLE && (cfgOffset == 8'(PEND_OFF));
    strb.doWrite   = cfgHit && cfgWrite;
    strb.launch    = launch;
    strb.launchVec = pickVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       msgValid <= 1'b0;
    else if (launch) msgValid <= 1'b1;
    else if (msgAck) msgValid <= 1'b0;
  end
endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
#(
  parameter bit       ADDR64   = 1'b1,
  parameter bit       MASKABLE = 1'b1,
  parameter bit [2:0] MMC_LOG2 = 3'd3,
  parameter bit [7:0] CAP_ID   = 8'h05,
  parameter bit [7:0] NEXT_PTR = 8'h00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [31:0]          cfgWdata,
  input  logic [3:0]           cfgByteEn,
  input  logic                 irqReq,
  input  logic [MSI_VEC_W-1:0] irqVec,
  output status_t              stat,
  output logic [31:0]          cfgRdata,
  output logic                 enabledPulse,
  output logic                 disabledPulse,
  output logic                 routeUpdate,
  output logic [63:0]          msgAddr,
  output logic [15:0]          msgData
);
  logic ctrlEn, extEn;
  logic [2:0] mme;
  logic [31:0] addrLo, addrHi, dataWord, maskBits, pendBits;

  logic ctrlEnN, extEnN;
  logic [2:0] mmeN;
  logic [31:0] addrLoN, addrHiN, dataWordN, maskBitsN, pendBitsN;
  logic [31:0] hdrMerged;
  logic [15:0] ctrlWord, lowMask;
  logic [MSI_VECS-1:0] setVec, clrVec;
  logic changed;

  assign ctrlWord = {5'd0, extEn, 1'b0, MASKABLE, ADDR64, mme, MMC_LOG2, ctrlEn};
  assign hdrMerged = mergeBytes({ctrlWord, NEXT_PTR, CAP_ID}, cfgWdata, cfgByteEn);

  assign setVec = (irqReq && ctrlEn) ? (MSI_VECS'(1) << irqVec) : '0;
  assign clrVec = strb.launch ? (MSI_VECS'(1) << strb.launchVec) : '0;

  always_comb begin
    ctrlEnN   = ctrlEn;
    mmeN      = mme;
    extEnN    = extEn;
    addrLoN   = addrLo;
    addrHiN   = addrHi;
    dataWordN = dataWord;
    maskBitsN = maskBits;
    if (strb.doWrite) begin
      if (strb.selHdr) begin
        ctrlEnN = hdrMerged[16];
        mmeN    = hdrMerged[22:20];
        extEnN  = hdrMerged[26];
      end
      if (strb.selAddrLo) addrLoN   = mergeBytes(addrLo, cfgWdata, cfgByteEn) & 32'hFFFF_FFFC;
      if (strb.selAddrHi) addrHiN   = mergeBytes(addrHi, cfgWdata, cfgByteEn);
      if (strb.selData)   dataWordN = mergeBytes(dataWord, cfgWdata, cfgByteEn);
      if (strb.selMask)   maskBitsN = mergeBytes(maskBits, cfgWdata, cfgByteEn);
    end
    pendBitsN = (pendBits & ~clrVec) | setVec;
  end

  assign changed = ({addrHiN, addrLoN} != {addrHi, addrLo}) || (dataWordN[15:0] != dataWord[15:0]);
  assign lowMask = (16'd1 << mme) - 16'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn        <= 1'b0;
      mme           <= 3'd0;
      extEn         <= 1'b0;
      addrLo        <= '0;
      addrHi        <= '0;
      dataWord      <= '0;
      maskBits      <= '0;
      pendBits      <= '0;
      enabledPulse  <= 1'b0;
      disabledPulse <= 1'b0;
      routeUpdate   <= 1'b0;
      msgAddr       <= '0;
      msgData       <= '0;
    end else begin
      ctrlEn        <= ctrlEnN;
      mme           <= mmeN;
      extEn         <= extEnN;
      addrLo        <= addrLoN;
      addrHi        <= addrHiN;
      dataWord      <= dataWordN;
      maskBits      <= maskBitsN;
      pendBits      <= pendBitsN;
      enabledPulse  <= strb.doWrite && strb.selHdr && ctrlEnN && !ctrlEn;
      disabledPulse <= strb.doWrite && strb.selHdr && !ctrlEnN && ctrlEn;
      routeUpdate   <= strb.doWrite && ctrlEnN && changed;
      if (strb.launch) begin
        msgAddr <= {addrHi, addrLo};
        msgData <= (dataWord[15:0] & ~lowMask) | ({11'd0, strb.launchVec} & lowMask);
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (strb.selHdr)    cfgRdata = {ctrlWord, NEXT_PTR, CAP_ID};
    if (strb.selAddrLo) cfgRdata = addrLo;
    if (strb.selAddrHi) cfgRdata = addrHi;
    if (strb.selData)   cfgRdata = dataWord;
    if (strb.selMask)   cfgRdata = maskBits;
    if (strb.selPend)   cfgRdata = pendBits;
  end

  assign stat.en    = ctrlEn;
  assign stat.ready = pendBits & ~maskBits;
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit       ADDR64   = 1'b1,
  parameter bit       MASKABLE = 1'b1,
  parameter bit [2:0] MMC_LOG2 = 3'd3,
  parameter bit [7:0] CAP_ID   = 8'h05,
  parameter bit [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgValid,
  input  logic        cfgWrite,
  input  logic [7:0]  cfgOffset,
  input  logic [3:0]  cfgByteEn,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        cfgHit,
  input  logic        irqReq,
  input  logic [4:0]  irqVec,
  output logic        msgValid,
  input  logic        msgAck,
  output logic [63:0] msgAddr,
  output logic [15:0] msgData,
  output logic        enabledPulse,
  output logic        disabledPulse,
  output logic        routeUpdate
);
  strobe_t strb;
  status_t stat;
  logic statusEn;

  assign statusEn = stat.en;

  msi_cap_ctrl #(.ADDR64(ADDR64), .MASKABLE(MASKABLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgOffset(cfgOffset), .cfgByteEn(cfgByteEn), .stat(stat),
    .msgAck(msgAck), .strb(strb), .cfgHit(cfgHit), .msgValid(msgValid)
  );

  msi_cap_dp #(.ADDR64(ADDR64), .MASKABLE(MASKABLE), .MMC_LOG2(MMC_LOG2),
               .CAP_ID(CAP_ID), .NEXT_PTR(NEXT_PTR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWdata(cfgWdata),
    .cfgByteEn(cfgByteEn), .irqReq(irqReq), .irqVec(irqVec), .stat(stat),
    .cfgRdata(cfgRdata), .enabledPulse(enabledPulse),
    .disabledPulse(disabledPulse), .routeUpdate(routeUpdate),
    .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgValid,
  input logic        cfgWrite,
  input logic        cfgHit,
  input logic        msgValid,
  input logic        msgAck,
  input logic [63:0] msgAddr,
  input logic [15:0] msgData,
  input logic        enabledPulse,
  input logic        disabledPulse,
  input logic        routeUpdate,
  input logic        en
);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgAck |=> msgValid && $stable(msgAddr) && $stable(msgData));

  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(enabledPulse && disabledPulse));

  a_r7_enabled_single: assert property (@(posedge clk) disable iff (!rstN)
    enabledPulse |=> !enabledPulse);

  a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgWrite && !cfgHit |=> !enabledPulse && !disabledPulse && !routeUpdate);

  a_r8_route_after_write: assert property (@(posedge clk) disable iff (!rstN)
    routeUpdate |-> $past(cfgValid && cfgWrite && cfgHit));

  a_r10_send_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(en));
endmodule

bind msi_cap_regs msi_cap_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgHit(cfgHit), .msgValid(msgValid), .msgAck(msgAck), .msgAddr(msgAddr),
  .msgData(msgData), .enabledPulse(enabledPulse), .disabledPulse(disabledPulse),
  .routeUpdate(routeUpdate), .en(statusEn)
);

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [7:0] cfgOffset = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWdata = '0;
  logic irqReq = 1'b0;
  logic [4:0] irqVec = '0;
  logic msgAck = 1'b0;
  logic [31:0] rdA, rdB;
  logic hitA, hitB, msgValid, msgValidB;
  logic [63:0] msgAddr, msgAddrB;
  logic [15:0] msgData, msgDataB;
  logic enP, disP, rtP, enPB, disPB, rtPB;
  logic capEn, capDis, capRt;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msi_cap_regs #(.ADDR64(1'b1), .MASKABLE(1'b1), .MMC_LOG2(3'd3),
                 .CAP_ID(8'h05), .NEXT_PTR(8'h00)) u_dut (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgOffset(cfgOffset), .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .cfgRdata(rdA), .cfgHit(hitA), .irqReq(irqReq), .irqVec(irqVec),
    .msgValid(msgValid), .msgAck(msgAck), .msgAddr(msgAddr), .msgData(msgData),
    .enabledPulse(enP), .disabledPulse(disP), .routeUpdate(rtP));

  msi_cap_regs #(.ADDR64(1'b0), .MASKABLE(1'b0), .MMC_LOG2(3'd3),
                 .CAP_ID(8'h05), .NEXT_PTR(8'h40)) u_dut32 (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgOffset(cfgOffset), .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .cfgRdata(rdB), .cfgHit(hitB), .irqReq(1'b0), .irqVec(5'd0),
    .msgValid(msgValidB), .msgAck(1'b0), .msgAddr(msgAddrB), .msgData(msgDataB),
    .enabledPulse(enPB), .disabledPulse(disPB), .routeUpdate(rtPB));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgValid = 1; cfgWrite = 1; cfgOffset = off; cfgByteEn = be; cfgWdata = d;
    @(negedge clk);
    capEn = enP; capDis = disP; capRt = rtP;
    cfgValid = 0; cfgWrite = 0;
  endtask

  task automatic cfgRd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    cfgValid = 1; cfgWrite = 0; cfgOffset = off; cfgByteEn = 4'hF;
    #1 d = rdA;
    @(negedge clk);
    cfgValid = 0;
  endtask

  task automatic raise(input logic [4:0] v);
    @(negedge clk);
    irqReq = 1; irqVec = v;
    @(negedge clk);
    irqReq = 0;
  endtask

  task automatic waitMsg(output bit got);
    got = 0;
    for (int i = 0; i < 10 && !got; i++) begin
      @(negedge clk);
      if (msgValid) got = 1;
    end
  endtask

  task automatic ack();
    @(negedge clk);
    msgAck = 1;
    @(negedge clk);
    msgAck = 0;
  endtask

  function automatic bit expHit(input int off, input logic [3:0] be, input int len);
    int hi = 0;
    for (int i = 0; i < 4; i++) if (be[i]) hi = i;
    return (be != 0) && (off % 4 == 0) && (off + hi < len);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit got;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset values
    check("R1 msgValid", {63'd0, msgValid}, 64'd0);
    cfgRd(8'd0, d);  check("R1 hdr64", d, 32'h0186_0005);
    @(negedge clk); cfgValid = 1; cfgOffset = 0; cfgByteEn = 4'hF;
    #1 check("R1 hdr32", rdB, 32'h0006_4005);
    @(negedge clk); cfgValid = 0;
    for (int o = 4; o <= 20; o += 4) begin
      cfgRd(8'(o), d); check("R1 zero field", d, 0);
    end

    // R2 hit sweep over both builds
    for (int o = 0; o < 32; o++) begin
      for (int b = 1; b < 16; b++) begin
        @(negedge clk);
        cfgValid = 1; cfgWrite = 0; cfgOffset = 8'(o); cfgByteEn = 4'(b);
        #1;
        check("R2 hit len24", {63'd0, hitA}, {63'd0, expHit(o, 4'(b), 24)});
        check("R2 hit len10", {63'd0, hitB}, {63'd0, expHit(o, 4'(b), 10)});
      end
    end
    @(negedge clk); cfgValid = 0;
    cfgWr(8'd24, 4'hF, 32'hFFFF_FFFF);
    check("R2 miss no event", {61'd0, capEn, capDis, capRt}, 0);
    cfgRd(8'd20, d); check("R2 miss no change", d, 0);

    // R3 / R7 control word
    cfgWr(8'd0, 4'hC, 32'hFFFF_0000);
    check("R7 enabled pulse", {62'd0, capEn, capDis}, 64'd2);
    cfgRd(8'd0, d); check("R3 ctrl mask", d, 32'h05F7_0005);
    cfgWr(8'd0, 4'hC, 32'hFFFF_0000);
    check("R7 no pulse on rewrite", {62'd0, capEn, capDis}, 0);
    cfgWr(8'd0, 4'h3, 32'h0000_FFFF);
    cfgRd(8'd0, d); check("R3 id readonly", d, 32'h05F7_0005);
    cfgWr(8'd0, 4'hC, 32'h0000_0000);
    check("R7 disabled pulse", {62'd0, capEn, capDis}, 64'd1);
    cfgRd(8'd0, d); check("R3 ctrl cleared", d, 32'h0186_0005);

    // R4 address low
    cfgWr(8'd4, 4'hF, 32'hFFFF_FFFF);
    cfgRd(8'd4, d); check("R4 low bits zero", d, 32'hFFFF_FFFC);
    cfgWr(8'd4, 4'h1, 32'h0000_0012);
    cfgRd(8'd4, d); check("R4 byte merge", d, 32'hFFFF_FF10);

    // R5 halves independent
    cfgWr(8'd8, 4'hF, 32'h1234_5678);
    cfgRd(8'd4, d); check("R5 low kept", d, 32'hFFFF_FF10);
    cfgWr(8'd4, 4'hF, 32'hABCD_0000);
    cfgRd(8'd8, d); check("R5 high kept", d, 32'h1234_5678);

    // R6 data, mask, pending
    cfgWr(8'd12, 4'hF, 32'hBEEF_1234);
    cfgRd(8'd12, d); check("R6 data", d, 32'hBEEF_1234);
    cfgWr(8'd16, 4'hF, 32'hFFFF_FFFF);
    cfgRd(8'd16, d); check("R6 mask", d, 32'hFFFF_FFFF);
    cfgWr(8'd20, 4'hF, 32'hFFFF_FFFF);
    cfgRd(8'd20, d); check("R6 pending readonly", d, 0);
    cfgWr(8'd16, 4'hF, 32'h0);

    // R8 route update, enable with mme=2
    cfgWr(8'd0, 4'hC, 32'h0021_0000);
    check("R8 enable alone no route", {62'd0, capEn, capRt}, 64'd2);
    cfgWr(8'd4, 4'hF, 32'hABCD_0004);
    check("R8 addr change", {63'd0, capRt}, 1);
    cfgWr(8'd4, 4'hF, 32'hABCD_0004);
    check("R8 same addr", {63'd0, capRt}, 0);
    cfgWr(8'd12, 4'h3, 32'h0000_1234);
    check("R8 same data", {63'd0, capRt}, 0);
    cfgWr(8'd12, 4'h3, 32'h0000_1230);
    check("R8 data change", {63'd0, capRt}, 1);
    cfgWr(8'd12, 4'h3, 32'h0000_1234);

    // R9 unmasked request
    raise(5'd5);
    waitMsg(got);
    check("R9 sent", {63'd0, got}, 1);
    check("R9 addr", msgAddr, 64'h1234_5678_ABCD_0004);
    check("R9 data", {48'd0, msgData}, 64'h1235);
    repeat (3) @(negedge clk);
    check("R9 held", {47'd0, msgValid, msgData}, {47'd0, 1'b1, 16'h1235});
    ack();
    check("R9 ack clears", {63'd0, msgValid}, 0);

    // R10 disabled request ignored
    cfgWr(8'd0, 4'hC, 32'h0020_0000);
    raise(5'd3);
    repeat (6) @(negedge clk);
    check("R10 no message", {63'd0, msgValid}, 0);
    cfgRd(8'd20, d); check("R10 no pending", d, 0);

    // R11 masked then unmasked
    cfgWr(8'd0, 4'hC, 32'h0021_0000);
    cfgWr(8'd16, 4'hF, 32'h0000_0080);
    raise(5'd7);
    repeat (6) @(negedge clk);
    check("R11 masked no message", {63'd0, msgValid}, 0);
    cfgRd(8'd20, d); check("R11 pending set", d, 32'h80);
    cfgWr(8'd16, 4'hF, 32'h0);
    waitMsg(got);
    check("R11 sent on unmask", {47'd0, got, msgData}, {47'd0, 1'b1, 16'h1237});
    ack();
    cfgRd(8'd20, d); check("R11 pending cleared", d, 0);

    // R12 lowest first
    cfgWr(8'd16, 4'hF, 32'h0000_0006);
    raise(5'd2);
    raise(5'd1);
    cfgRd(8'd20, d); check("R12 both pending", d, 32'h6);
    cfgWr(8'd16, 4'hF, 32'h0);
    waitMsg(got);
    check("R12 first vec1", {47'd0, got, msgData}, {47'd0, 1'b1, 16'h1235});
    ack();
    waitMsg(got);
    check("R12 second vec2", {47'd0, got, msgData}, {47'd0, 1'b1, 16'h1236});
    ack();
    cfgRd(8'd20, d); check("R12 drained", d, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule